// File: doc/BRIEF.md
# Single-Level Two-Source Interrupt Controller

This block sits beside a small 8-bit processor core and chooses between two interrupt sources. The first is an external request line that is active low and level sensitive. The second is a timer overflow event, which the block holds in a latch. When the core signals an instruction boundary and a request is pending, the block pulses a call request together with a 12-bit vector address. The external source uses vector 3 and the timer source uses vector 7. The core saves the program counter and status word and performs the jump. This block handles none of that.

Only one service can run at a time. Once a call is issued, an in-service flag masks every new request. The flag clears only when the core reports the second machine cycle of its return-and-restore instruction. The first cycle of that instruction does not clear it. If both sources are present at the same boundary, the external one is served. The timer request stays latched and is served at the first boundary after the return. The raw external pin is also passed back to the core as a test input, so software can poll it whatever the enable state.

Top module: `irqc_top`

## Requirements
- R1: After reset, call_req, call_vec and in_service are all 0 and both enables are cleared, so a low ext_irq_n with an instruction boundary produces no call.
- R2: With the external enable set, ext_irq_n low and the controller idle, an insn_bound strobe in cycle t gives call_req=1 with call_vec=3 in cycle t+1.
- R3: A tmr_ovf pulse while the timer enable is set is latched. A later insn_bound on an idle controller gives call_vec=7, and the latch clears, so that overflow produces only one call.
- R4: When an external request and a latched timer request are both present at the same boundary, call_vec=3. The timer request stays pending and gives call_vec=7 at the first boundary after the release.
- R5: While in_service=1, no call is issued. A return cycle with ret_cyc2=0 leaves in_service set. A cycle with ret_exec=1 and ret_cyc2=1 clears in_service at the next clock edge.
- R6: If ext_irq_n is still low when in_service is released, the next insn_bound issues call_vec=3 again.
- R7: cmd_tmr_dis clears any latched timer request. A tmr_ovf pulse while the timer enable is clear is not latched. In both cases a later boundary after re-enabling issues no timer call.
- R8: No call is issued in any cycle that does not follow an insn_bound strobe.
- R9: pin_test always equals ext_irq_n, with or without the enables set.
- R10: A disable command in the same cycle as the matching enable command leaves the source disabled.
- R11: call_req lasts exactly one cycle, and call_vec is 0 whenever call_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_n | input | 1 | External request, active low, level sensitive, already synchronous |
| tmr_ovf | input | 1 | One-cycle timer overflow event |
| cmd_ext_en | input | 1 | Set the external enable |
| cmd_ext_dis | input | 1 | Clear the external enable (wins over set) |
| cmd_tmr_en | input | 1 | Set the timer enable |
| cmd_tmr_dis | input | 1 | Clear the timer enable and drop the latched request |
| ret_exec | input | 1 | Return-and-restore instruction executing |
| ret_cyc2 | input | 1 | Marks the second machine cycle of that return |
| insn_bound | input | 1 | Instruction boundary, the only point where requests are sampled |
| call_req | output | 1 | One-cycle call pulse |
| call_vec | output | 12 | Vector address, valid with call_req |
| in_service | output | 1 | A service is running and all requests are masked |
| pin_test | output | 1 | Raw state of ext_irq_n for polling |

## Verification
Several events can land in the same cycle, and the bench creates each case on purpose. A timer overflow can arrive in the same cycle as the timer call that clears the latch. A boundary can arrive in the same cycle as the second return cycle. An external request can meet a latched timer request at one boundary. A disable can arrive together with its matching enable. Directed sequences build each of these collisions. A long seeded random run then mixes them freely. At every cycle, a cycle-accurate reference model computes the expected call pulse, vector and in-service flag from the requirements, and the bench compares the outputs against it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Which source a call serves.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_TMR  = 2'd2
  } irq_src_e;
endpackage

// File: rtl/irqc_enable.sv
// One enable flip-flop. The clear command wins over the set command.
module irqc_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o
);
  logic en_q, en_d, en_ce;

  always_comb begin
    en_ce = set_i | clr_i;
    en_d  = set_i & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_ce) en_q <= en_d;
  end

  assign en_o = en_q;

  assert_clr_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !en_o);
  assert_set_takes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> en_o);
endmodule

// File: rtl/irqc_tmr_latch.sv
// Holds a timer overflow until its call is issued or the timer is disabled.
module irqc_tmr_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_i,
  input  logic en_i,
  input  logic dis_i,
  input  logic taken_i,
  output logic pend_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = (pend_q & ~taken_i & ~dis_i) | (ovf_i & en_i & ~dis_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // A pending request only exists while the timer source is enabled.
  assert_pend_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o |-> en_i);
  assert_taken_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_i && !ovf_i) |=> !pend_o);
  assert_dis_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dis_i |=> !pend_o);
endmodule

// File: rtl/irqc_arbiter.sv
// Samples requests at a boundary, picks the winning source, issues the call
// and holds the single in-service mask.
module irqc_arbiter #(
  parameter int unsigned VEC_W   = 12,
  parameter int unsigned EXT_VEC = 3,
  parameter int unsigned TMR_VEC = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bound_i,
  input  logic             ext_req_i,
  input  logic             tmr_req_i,
  input  logic             ret_exec_i,
  input  logic             ret_cyc2_i,
  output logic             call_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             svc_o,
  output logic             tmr_taken_o
);
  import irqc_pkg::*;

  localparam logic [VEC_W-1:0] EXT_ADDR = VEC_W'(EXT_VEC);
  localparam logic [VEC_W-1:0] TMR_ADDR = VEC_W'(TMR_VEC);

  logic             svc_q, svc_d;
  logic             call_q, call_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             take, release_svc;
  irq_src_e         pick;

  always_comb begin
    take        = bound_i & ~svc_q & (ext_req_i | tmr_req_i);
    release_svc = ret_exec_i & ret_cyc2_i;
    if (!take)          pick = SRC_NONE;
    else if (ext_req_i) pick = SRC_EXT;
    else                pick = SRC_TMR;
    svc_d  = take | (svc_q & ~release_svc);
    call_d = take;
    unique case (pick)
      SRC_EXT: vec_d = EXT_ADDR;
      SRC_TMR: vec_d = TMR_ADDR;
      default: vec_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_q  <= 1'b0;
      call_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      svc_q  <= svc_d;
      call_q <= call_d;
      vec_q  <= vec_d;
    end
  end

  assign call_o      = call_q;
  assign vec_o       = vec_q;
  assign svc_o       = svc_q;
  assign tmr_taken_o = (pick == SRC_TMR);

  assert_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_o |=> !call_o);
  assert_first_cycle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_o && !(ret_exec_i && ret_cyc2_i) && !call_o) |=> svc_o);
  assert_needs_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> $past(bound_i));
  assert_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |=> !call_o);
  assert_vec_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !call_o |-> (vec_o == '0));
  assert_ext_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bound_i && !svc_o && ext_req_i && tmr_req_i) |=> (call_o && vec_o == EXT_ADDR));
  assert_tmr_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bound_i && !svc_o && !ext_req_i && tmr_req_i) |=> (call_o && vec_o == TMR_ADDR));
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int unsigned VEC_W   = 12,
  parameter int unsigned EXT_VEC = 3,
  parameter int unsigned TMR_VEC = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_irq_n,
  input  logic             tmr_ovf,
  input  logic             cmd_ext_en,
  input  logic             cmd_ext_dis,
  input  logic             cmd_tmr_en,
  input  logic             cmd_tmr_dis,
  input  logic             ret_exec,
  input  logic             ret_cyc2,
  input  logic             insn_bound,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec,
  output logic             in_service,
  output logic             pin_test
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic ext_en, tmr_en, tmr_pend, tmr_taken, ext_req;

  irqc_enable u_ext_en (
    .clk(clk), .rst_n(rst_sync_n),
    .set_i(cmd_ext_en), .clr_i(cmd_ext_dis), .en_o(ext_en)
  );

  irqc_enable u_tmr_en (
    .clk(clk), .rst_n(rst_sync_n),
    .set_i(cmd_tmr_en), .clr_i(cmd_tmr_dis), .en_o(tmr_en)
  );

  irqc_tmr_latch u_tmr_latch (
    .clk(clk), .rst_n(rst_sync_n),
    .ovf_i(tmr_ovf), .en_i(tmr_en), .dis_i(cmd_tmr_dis),
    .taken_i(tmr_taken), .pend_o(tmr_pend)
  );

  assign ext_req = ext_en & ~ext_irq_n;

  irqc_arbiter #(
    .VEC_W(VEC_W), .EXT_VEC(EXT_VEC), .TMR_VEC(TMR_VEC)
  ) u_arbiter (
    .clk(clk), .rst_n(rst_sync_n),
    .bound_i(insn_bound), .ext_req_i(ext_req), .tmr_req_i(tmr_pend),
    .ret_exec_i(ret_exec), .ret_cyc2_i(ret_cyc2),
    .call_o(call_req), .vec_o(call_vec), .svc_o(in_service),
    .tmr_taken_o(tmr_taken)
  );

  assign pin_test = ext_irq_n;

  assert_pin_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pin_test == ext_irq_n);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (!call_req && !in_service));
endmodule

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_irq_n, tmr_ovf, cmd_ext_en, cmd_ext_dis, cmd_tmr_en, cmd_tmr_dis;
  logic        ret_exec, ret_cyc2, insn_bound;
  logic        call_req, in_service, pin_test;
  logic [11:0] call_vec;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irqc_top i_irqc_top (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .tmr_ovf(tmr_ovf),
    .cmd_ext_en(cmd_ext_en), .cmd_ext_dis(cmd_ext_dis),
    .cmd_tmr_en(cmd_tmr_en), .cmd_tmr_dis(cmd_tmr_dis),
    .ret_exec(ret_exec), .ret_cyc2(ret_cyc2), .insn_bound(insn_bound),
    .call_req(call_req), .call_vec(call_vec), .in_service(in_service),
    .pin_test(pin_test)
  );

  // Reference model built from the requirements.
  logic        m_ext_en, m_tmr_en, m_lat, m_svc, m_call;
  logic [11:0] m_vec;

  function automatic logic [11:0] exp_vec(logic take, logic ext);
    if (!take) return 12'd0;
    return ext ? 12'd3 : 12'd7;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ext_en <= 0; m_tmr_en <= 0; m_lat <= 0; m_svc <= 0; m_call <= 0; m_vec <= 0;
    end else begin
      automatic logic ext  = m_ext_en & ~ext_irq_n;
      automatic logic take = insn_bound & ~m_svc & (ext | m_lat);
      m_call   <= take;
      m_vec    <= exp_vec(take, ext);
      m_svc    <= take | (m_svc & ~(ret_exec & ret_cyc2));
      m_lat    <= (m_lat & ~(take & ~ext) & ~cmd_tmr_dis) | (tmr_ovf & m_tmr_en & ~cmd_tmr_dis);
      m_ext_en <= cmd_ext_dis ? 1'b0 : (cmd_ext_en ? 1'b1 : m_ext_en);
      m_tmr_en <= cmd_tmr_dis ? 1'b0 : (cmd_tmr_en ? 1'b1 : m_tmr_en);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model(string tag);
    chk({tag, " call_req"}, 32'(call_req), 32'(m_call));
    chk({tag, " call_vec"}, 32'(call_vec), 32'(m_vec));
    chk({tag, " in_service"}, 32'(in_service), 32'(m_svc));
    chk("R9 pin_test", 32'(pin_test), 32'(ext_irq_n));
  endtask

  task automatic clr_strobes();
    tmr_ovf = 0; cmd_ext_en = 0; cmd_ext_dis = 0; cmd_tmr_en = 0; cmd_tmr_dis = 0;
    ret_exec = 0; ret_cyc2 = 0; insn_bound = 0;
  endtask

  // One clock: inputs already driven; compare after the edge, then clear strobes.
  task automatic tick(string tag);
    @(posedge clk);
    @(negedge clk);
    cmp_model(tag);
    clr_strobes();
  endtask

  task automatic ret2();
    ret_exec = 1; ret_cyc2 = 0; tick("R5 ret c1");
    chk("R5 first return cycle keeps mask", 32'(in_service), 32'd1);
    ret_exec = 1; ret_cyc2 = 1; tick("R5 ret c2");
    chk("R5 second return cycle releases", 32'(in_service), 32'd0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; ext_irq_n = 1; clr_strobes();
    repeat (3) @(negedge clk);
    chk("R1 reset call_req", 32'(call_req), 32'd0);
    chk("R1 reset call_vec", 32'(call_vec), 32'd0);
    chk("R1 reset in_service", 32'(in_service), 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: enables cleared after reset.
    ext_irq_n = 0; insn_bound = 1; tick("R1");
    chk("R1 no call while disabled", 32'(call_req), 32'd0);

    // R8: pending request without boundary.
    cmd_ext_en = 1; tick("R8");
    for (int i = 0; i < 3; i++) begin
      tick("R8");
      chk("R8 no call without boundary", 32'(call_req), 32'd0);
    end

    // R2 and R11.
    insn_bound = 1; tick("R2");
    chk("R2 call", 32'(call_req), 32'd1);
    chk("R2 vector 3", 32'(call_vec), 32'd3);
    tick("R11");
    chk("R11 single pulse", 32'(call_req), 32'd0);
    chk("R11 vec idle", 32'(call_vec), 32'd0);

    // R5: masked while in service.
    insn_bound = 1; tick("R5");
    chk("R5 masked", 32'(call_req), 32'd0);
    ret_exec = 1; ret_cyc2 = 0; insn_bound = 1; tick("R5");
    chk("R5 masked in first return cycle", 32'(call_req), 32'd0);
    ret_exec = 1; ret_cyc2 = 1; insn_bound = 1; tick("R5");
    chk("R5 boundary with release still masked", 32'(call_req), 32'd0);
    chk("R5 released", 32'(in_service), 32'd0);

    // R6: pin still low, immediate re-entry.
    insn_bound = 1; tick("R6");
    chk("R6 re-entry", 32'(call_req), 32'd1);
    chk("R6 vector", 32'(call_vec), 32'd3);
    ext_irq_n = 1; ret2();
    insn_bound = 1; tick("R6");
    chk("R6 no call after pin released", 32'(call_req), 32'd0);

    // R3: timer path.
    cmd_tmr_en = 1; tick("R3");
    tmr_ovf = 1; tick("R3");
    insn_bound = 1; tick("R3");
    chk("R3 timer call", 32'(call_req), 32'd1);
    chk("R3 vector 7", 32'(call_vec), 32'd7);
    ret2();
    insn_bound = 1; tick("R3");
    chk("R3 latch cleared by call", 32'(call_req), 32'd0);

    // R4: tie.
    tmr_ovf = 1; ext_irq_n = 0; tick("R4");
    insn_bound = 1; tick("R4");
    chk("R4 external wins", 32'(call_vec), 32'd3);
    ext_irq_n = 1; ret2();
    insn_bound = 1; tick("R4");
    chk("R4 timer taken after return", 32'(call_vec), 32'd7);
    ret2();

    // R7: disable drops latch; overflow while disabled ignored.
    tmr_ovf = 1; tick("R7");
    cmd_tmr_dis = 1; tick("R7");
    cmd_tmr_en = 1; tick("R7");
    insn_bound = 1; tick("R7");
    chk("R7 dropped by disable", 32'(call_req), 32'd0);
    cmd_tmr_dis = 1; tick("R7");
    tmr_ovf = 1; tick("R7");
    cmd_tmr_en = 1; tick("R7");
    insn_bound = 1; tick("R7");
    chk("R7 overflow while disabled ignored", 32'(call_req), 32'd0);

    // R10: disable wins.
    cmd_ext_dis = 1; tick("R10");
    cmd_ext_en = 1; cmd_ext_dis = 1; ext_irq_n = 0; tick("R10");
    insn_bound = 1; tick("R10");
    chk("R10 disable wins", 32'(call_req), 32'd0);
    chk("R9 pin readable while disabled", 32'(pin_test), 32'd0);

    // Random mix: overflow with take, boundary with release, ties.
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(9) == 0) ext_irq_n = ~ext_irq_n;
      tmr_ovf     = ($urandom_range(9) == 0);
      insn_bound  = ($urandom_range(9) < 4);
      cmd_ext_en  = ($urandom_range(19) == 0);
      cmd_ext_dis = ($urandom_range(39) == 0);
      cmd_tmr_en  = ($urandom_range(19) == 0);
      cmd_tmr_dis = ($urandom_range(39) == 0);
      ret_exec    = ($urandom_range(7) == 0);
      ret_cyc2    = ret_exec & ($urandom_range(1) == 1);
      tick("random R2 R3 R4 R5 R6 R7 R8 R10 R11");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule